// File: doc/BRIEF.md
# Suspend Request and Acknowledge Controller

This block moves a processor core into a low-power suspended state and back out again. Entry can come from two places. The first is an external suspend request line, which is active low, level sensitive, and reads as inactive when nothing drives it. The second is a strobe the core raises when it executes a HALT instruction. Software must first set a configuration enable before either path can act. After any reset the mechanism stays disabled, so a request line held low through reset has no effect.

When an entry is accepted, the controller does not suspend at once. It waits until the instruction in flight, the queue of already-decoded instructions and the outstanding bus cycles have all drained. Only then does it stop clocks and assert the active-low acknowledge. A gating-mode input, captured when the entry is accepted, selects what is stopped: only the core clock, or every clock. On exit the clock enables come back one cycle before the acknowledge is released.

Top module: `lp_suspend_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `susp_ack_n`, `core_clk_en` and `sys_clk_en` are all 1.
- R2: `susp_req_n` is active low and passes through a two-stage synchroniser. It is accepted only when `cfg_susp_en` is 1 and `insn_boundary` is 1. While `cfg_susp_en` is 0, a held request is ignored, including one held through reset.
- R3: After an entry is accepted, suspend begins only in the cycle after all of `idle_flags` are 1. Bit 0 means the instruction is done, bit 1 means the decode queue is empty, and bit 2 means the bus is idle. While any bit is 0, `susp_ack_n` stays 1.
- R4: On entering suspend, `susp_ack_n` and `core_clk_en` go to 0 in the same cycle. `sys_clk_en` also goes to 0 only when `cfg_gate_all` was 1 at acceptance.
- R5: A one-cycle `halt_stb` with `cfg_susp_en` at 1 starts an entry. A suspend started this way ends when `wake_irq` is 1.
- R6: A request-started suspend ends two cycles after `susp_req_n` returns high, plus one cycle for the state change. The clock enables return to 1 while `susp_ack_n` is still 0, and `susp_ack_n` rises one cycle later.
- R7: A request-started suspend ignores `wake_irq`. A HALT-started suspend ignores the request line.
- R8: Clearing `cfg_susp_en` before suspend is reached drops the pending entry, and `susp_ack_n` stays 1. A `halt_stb` while it is 0 is ignored.
- R9: If the synchronised request goes inactive while draining, the block returns to normal running without acknowledging.
- R10: The gating mode is held for the whole suspend. Changes to `cfg_gate_all` while suspended do not change `sys_clk_en`.
- R11: If a request and `halt_stb` are accepted in the same cycle, the request path owns the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_susp_en | input | 1 | Configuration enable for the whole mechanism |
| cfg_gate_all | input | 1 | Gating mode: 0 stops core clock only, 1 stops all clocks |
| susp_req_n | input | 1 | Asynchronous active-low suspend request |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| halt_stb | input | 1 | Core executed HALT (one-cycle strobe) |
| idle_flags | input | N_DRAIN (3) | Drain handshakes: bit0 instruction, bit1 decode queue, bit2 bus |
| wake_irq | input | 1 | Unmasked interrupt pending, wakes HALT suspend |
| susp_ack_n | output | 1 | Active-low suspend acknowledge |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System (all other) clock enable |

## Verification
All outputs are decoded from the state register, so a condition seen at one clock edge shows at the ports just after that edge. The `halt_stb` path and the drain check each take effect one edge after they are presented. A change on `susp_req_n` needs two synchroniser edges and then one state edge, so its first visible effect comes after the third edge. An exit shows the clock enables back after one more edge and the acknowledge released after the edge after that. The bench drives inputs one time unit after a rising edge, advances exactly the counted number of edges, and samples there. It also samples one edge early to confirm that nothing has moved yet.

// File: rtl/lp_susp_pkg.sv
package lp_susp_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRAIN = 2'd1,
      ST_SUSP  = 2'd2,
      ST_WAKE  = 2'd3
   } susp_state_e;

   typedef enum logic {
      SRC_REQ  = 1'b0,
      SRC_HALT = 1'b1
   } susp_src_e;
endpackage

// File: rtl/lp_susp_sync.sv
module lp_susp_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lp_susp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lp_susp_drain.sv
module lp_susp_drain #(
   parameter int N_DRAIN = 3
) (
   input  logic [N_DRAIN-1:0] idle_flags,
   output logic               drained
);
   if (N_DRAIN < 1) begin : g_bad_n
      $error("lp_susp_drain: N_DRAIN must be at least 1");
   end

   logic [N_DRAIN:0] acc;
   assign acc[0] = 1'b1;
   for (genvar i = 0; i < N_DRAIN; i++) begin : g_and
      assign acc[i+1] = acc[i] & idle_flags[i];
   end
   assign drained = acc[N_DRAIN];
endmodule

// File: rtl/lp_susp_fsm.sv
module lp_susp_fsm
   import lp_susp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_en,
   input  logic        cfg_all,
   input  logic        req_act,
   input  logic        boundary,
   input  logic        halt_stb,
   input  logic        drained,
   input  logic        wake_irq,
   output susp_state_e state_q,
   output logic        mode_all_q
);
   susp_state_e state_d;
   susp_src_e   src_q, src_d;
   logic        mode_d;
   logic        accept_req, accept;

   assign accept_req = req_act & boundary;
   assign accept     = cfg_en & (accept_req | halt_stb);

   always_comb begin
      state_d = state_q;
      src_d   = src_q;
      mode_d  = mode_all_q;
      unique case (state_q)
         ST_RUN: begin
            if (accept) begin
               state_d = ST_DRAIN;
               src_d   = accept_req ? SRC_REQ : SRC_HALT;
               mode_d  = cfg_all;
            end
         end
         ST_DRAIN: begin
            if (!cfg_en || (src_q == SRC_REQ && !req_act)) state_d = ST_RUN;
            else if (drained)                              state_d = ST_SUSP;
         end
         ST_SUSP: begin
            if ((src_q == SRC_REQ && !req_act) ||
                (src_q == SRC_HALT && wake_irq))
               state_d = ST_WAKE;
         end
         ST_WAKE: state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         src_q      <= SRC_REQ;
         mode_all_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         src_q      <= src_d;
         mode_all_q <= mode_d;
      end
   end
endmodule

// File: rtl/lp_susp_gate.sv
module lp_susp_gate
   import lp_susp_pkg::*;
#(
   parameter bit ALL_CLK_OK = 1'b1
) (
   input  susp_state_e state,
   input  logic        mode_all,
   output logic        ack_n,
   output logic        core_en,
   output logic        sys_en
);
   assign ack_n   = !(state == ST_SUSP || state == ST_WAKE);
   assign core_en = (state != ST_SUSP);

   if (ALL_CLK_OK) begin : g_all_clk
      assign sys_en = !(state == ST_SUSP && mode_all);
   end else begin : g_core_only
      logic unused_mode;
      assign unused_mode = mode_all;
      assign sys_en      = 1'b1;
   end
endmodule

// File: rtl/lp_suspend_ctrl.sv
module lp_suspend_ctrl
   import lp_susp_pkg::*;
#(
   parameter int N_DRAIN     = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit ALL_CLK_OK  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_susp_en,
   input  logic               cfg_gate_all,
   input  logic               susp_req_n,
   input  logic               insn_boundary,
   input  logic               halt_stb,
   input  logic [N_DRAIN-1:0] idle_flags,
   input  logic               wake_irq,
   output logic               susp_ack_n,
   output logic               core_clk_en,
   output logic               sys_clk_en
);
   logic        req_n_s, drained, mode_all;
   susp_state_e state;

   lp_susp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (susp_req_n),
      .q_sync  (req_n_s)
   );

   lp_susp_drain #(.N_DRAIN(N_DRAIN)) u_drain (
      .idle_flags (idle_flags),
      .drained    (drained)
   );

   lp_susp_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_en     (cfg_susp_en),
      .cfg_all    (cfg_gate_all),
      .req_act    (~req_n_s),
      .boundary   (insn_boundary),
      .halt_stb   (halt_stb),
      .drained    (drained),
      .wake_irq   (wake_irq),
      .state_q    (state),
      .mode_all_q (mode_all)
   );

   lp_susp_gate #(.ALL_CLK_OK(ALL_CLK_OK)) u_gate (
      .state    (state),
      .mode_all (mode_all),
      .ack_n    (susp_ack_n),
      .core_en  (core_clk_en),
      .sys_en   (sys_clk_en)
   );
endmodule

// File: rtl/lp_suspend_ctrl_chk.sv
module lp_suspend_ctrl_chk #(
   parameter int N_DRAIN = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_susp_en,
   input logic [N_DRAIN-1:0] idle_flags,
   input logic               susp_ack_n,
   input logic               core_clk_en,
   input logic               sys_clk_en
);
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |-> (susp_ack_n && core_clk_en && sys_clk_en));

   p_drained_before_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(susp_ack_n) |-> $past(&idle_flags));

   p_core_stop_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> !susp_ack_n);

   p_sys_stop_implies_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_clk_en |-> !core_clk_en);

   p_ack_release_after_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_clk_en) |-> (!susp_ack_n && sys_clk_en));

   p_ack_follows_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_clk_en) |=> susp_ack_n);

   p_ack_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(susp_ack_n) |-> $past(cfg_susp_en));

   p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_clk_en && $past(!core_clk_en)) |-> $stable(sys_clk_en));
endmodule

bind lp_suspend_ctrl lp_suspend_ctrl_chk #(.N_DRAIN(N_DRAIN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_susp_en (cfg_susp_en),
   .idle_flags  (idle_flags),
   .susp_ack_n  (susp_ack_n),
   .core_clk_en (core_clk_en),
   .sys_clk_en  (sys_clk_en)
);

// File: tb/lp_suspend_ctrl_test.sv
`timescale 1ns/1ps
module lp_suspend_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_susp_en, cfg_gate_all, susp_req_n, insn_boundary, halt_stb, wake_irq;
   logic [2:0] idle_flags;
   logic       susp_ack_n, core_clk_en, sys_clk_en;
   int         tests = 0;
   int         fails = 0;

   // bit1 = gate all clocks, bit0 = HALT entry (else request entry)
   localparam logic [1:0] VECS [4] = '{2'b00, 2'b10, 2'b01, 2'b11};

   always #2 clk = ~clk;

   lp_suspend_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_susp_en(cfg_susp_en), .cfg_gate_all(cfg_gate_all),
      .susp_req_n(susp_req_n), .insn_boundary(insn_boundary), .halt_stb(halt_stb),
      .idle_flags(idle_flags), .wake_irq(wake_irq), .susp_ack_n(susp_ack_n),
      .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [2:0] exp);
      logic [2:0] act;
      act = {susp_ack_n, core_clk_en, sys_clk_en};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {ack_n,core_en,sys_en} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   task automatic exit_req(input logic all);
      susp_req_n = 1'b1;
      tick(2);
      chk("R6 still suspended during sync", {1'b0, 1'b0, ~all});
      tick();
      chk("R6 clocks back, ack held", 3'b011);
      tick();
      chk("R6 ack released", 3'b111);
   endtask

   task automatic exit_halt();
      wake_irq = 1'b1;
      tick();
      chk("R5 irq wake clocks back", 3'b011);
      wake_irq = 1'b0;
      tick();
      chk("R5 ack released", 3'b111);
   endtask

   task automatic enter_halt(input logic all);
      cfg_gate_all = all;
      halt_stb = 1'b1;
      tick();
      halt_stb = 1'b0;
      chk("R5 halt drain no ack", 3'b111);
      idle_flags = 3'b110;
      tick();
      chk("R3 insn busy no ack", 3'b111);
      idle_flags = 3'b111;
      tick();
      chk("R4 halt suspend gating", {1'b0, 1'b0, ~all});
      idle_flags = 3'b000;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_susp_en = 1'b0; cfg_gate_all = 1'b0; susp_req_n = 1'b0;
      insn_boundary = 1'b1; halt_stb = 1'b0; wake_irq = 1'b0; idle_flags = 3'b111;
      tick(3);
      chk("R1 reset outputs", 3'b111);
      rst_n = 1'b1;
      tick();
      chk("R1 first cycle after reset", 3'b111);
      tick(5);
      chk("R2 request held through reset ignored while disabled", 3'b111);
      cfg_susp_en = 1'b1;
      tick();
      chk("R2 enable accepts held request, draining", 3'b111);
      tick();
      chk("R4 core-only suspend", 3'b001);
      idle_flags = 3'b000;
      exit_req(1'b0);

      // vector table: mode x entry path
      foreach (VECS[i]) begin
         logic all;
         all = VECS[i][1];
         cfg_gate_all = all;
         if (!VECS[i][0]) begin
            susp_req_n = 1'b0;
            tick(3);
            chk("R2 request accepted, draining", 3'b111);
            idle_flags = 3'b011;
            tick(2);
            chk("R3 bus busy no ack", 3'b111);
            idle_flags = 3'b101;
            tick();
            chk("R3 decode queue busy no ack", 3'b111);
            idle_flags = 3'b111;
            tick();
            chk("R4 request suspend gating", {1'b0, 1'b0, ~all});
            idle_flags = 3'b000;
            wake_irq = 1'b1;
            tick(2);
            chk("R7 irq ignored in request suspend", {1'b0, 1'b0, ~all});
            wake_irq = 1'b0;
            exit_req(all);
         end else begin
            enter_halt(all);
            susp_req_n = 1'b0;
            tick(4);
            susp_req_n = 1'b1;
            tick(4);
            chk("R7 request line ignored in halt suspend", {1'b0, 1'b0, ~all});
            exit_halt();
         end
      end

      // instruction boundary gating
      cfg_gate_all = 1'b0;
      insn_boundary = 1'b0;
      idle_flags = 3'b111;
      susp_req_n = 1'b0;
      tick(6);
      chk("R2 no acceptance off boundary", 3'b111);
      insn_boundary = 1'b1;
      tick();
      chk("R2 boundary accept, draining", 3'b111);
      tick();
      chk("R4 suspend after boundary", 3'b001);
      idle_flags = 3'b000;
      exit_req(1'b0);

      // enable cleared while draining
      susp_req_n = 1'b0;
      tick(3);
      cfg_susp_en = 1'b0;
      tick();
      idle_flags = 3'b111;
      tick(3);
      chk("R8 cleared enable drops pending request", 3'b111);
      halt_stb = 1'b1;
      tick();
      halt_stb = 1'b0;
      tick(2);
      chk("R8 halt ignored while disabled", 3'b111);
      susp_req_n = 1'b1;
      idle_flags = 3'b000;
      tick(3);
      cfg_susp_en = 1'b1;

      // request withdrawn while draining
      susp_req_n = 1'b0;
      tick(3);
      susp_req_n = 1'b1;
      tick(3);
      idle_flags = 3'b111;
      tick(2);
      chk("R9 withdrawn request no ack", 3'b111);
      idle_flags = 3'b000;

      // gating mode frozen while suspended
      enter_halt(1'b0);
      cfg_gate_all = 1'b1;
      tick(2);
      chk("R10 mode change ignored in suspend", 3'b001);
      exit_halt();
      cfg_gate_all = 1'b0;

      // simultaneous request and halt: request path owns exit
      susp_req_n = 1'b0;
      tick(2);
      halt_stb = 1'b1;
      tick();
      halt_stb = 1'b0;
      idle_flags = 3'b111;
      tick();
      chk("R11 suspended on joint entry", 3'b001);
      idle_flags = 3'b000;
      wake_irq = 1'b1;
      tick(2);
      chk("R11 irq does not wake joint entry", 3'b001);
      wake_irq = 1'b0;
      exit_req(1'b0);

      summary();
      $finish;
   end
endmodule